// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Idle Timeout

This block holds the bytes a serial receiver has assembled until the host reads them. It sits between a deserializer and the data-register read path of a 16550-style UART. It has two modes. In queue mode, bytes go into a circular store and leave oldest first. A programmable fill threshold raises `trig_hit`. An idle detector raises `timeout_pend` when data has waited four character times without traffic. In single-register mode, one holding register takes each byte, and a later byte overwrites it.

A one-byte control register sets the behaviour. Bit 0 selects queue mode. Bit 1 and bit 2 are reset requests for the receive store and the transmit store; they act once and do not stick. Bit 3 is kept as a plain option bit. Bits 7:6 select the threshold. The transmit store lives elsewhere, so this block only emits a one-cycle `tx_flush` pulse for it. Character-time pacing arrives as a single-cycle `char_tick` from the baud generator.

Top module: `uart_rxq`

## Requirements
- R1: After a synchronous active-low reset: `level`, `data_ready`, `trig_hit`, `timeout_pend`, `tx_flush`, `overrun` and `ctl_q` are all 0, and `rd_data` is 0.
- R2: In queue mode (`ctl_q[0]`=1), accepted bytes leave in arrival order. `rd_data` always shows the oldest byte. `level` gives the number held. `data_ready` is 1 whenever `level` is non-zero. A `rd_strobe` removes the oldest byte, and its effect is visible in the next cycle.
- R3: In queue mode, a byte that arrives while `level` equals the depth (16) is dropped. The stored contents stay unchanged. `overrun` is high for exactly one cycle, in the cycle after that arrival. A read in the same cycle does not make room for it.
- R4: In queue mode with nothing stored, `rd_data` is 0, and a `rd_strobe` leaves `level` at 0.
- R5: In queue mode, `trig_hit` is 1 when `level` is at least the threshold set by `ctl_q[7:6]`. The encodings are 00 for 1 byte, 01 for 4 bytes, 10 for 8 bytes and 11 for 14 bytes.
- R6: A control write stores `ctl_wdata & 8'hC9` into `ctl_q`. This keeps bits 7, 6, 3 and 0. Bits 1 and 2 always read back as 0.
- R7: A control write with bit 1 set empties the receive store and cancels a pending timeout. A control write with bit 2 set makes `tx_flush` high for one cycle after the write. A write that changes bit 0 does both.
- R8: In queue mode, `timeout_pend` rises in the cycle after the fourth `char_tick` counted while data is held. An accepted byte, or a read that leaves data behind, restarts the count from zero.
- R9: A `rd_strobe` clears `timeout_pend` in the next cycle, and this takes priority over a tick arriving in the same cycle. A read that leaves data behind restarts the idle count.
- R10: In single-register mode (`ctl_q[0]`=0), each byte overwrites the holding register and sets `data_ready`, and `rd_data` shows it. A byte arriving while `data_ready` is already 1 pulses `overrun`. A read clears `data_ready`. `trig_hit` equals `data_ready`, and `timeout_pend` stays 0.
- R11: In a cycle where a control write resets the receive store, `rx_valid` and `rd_strobe` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is on `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Host read of the receive data register |
| char_tick | input | 1 | One pulse per character time |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| rd_data | output | 8 | Oldest byte (queue mode) or holding register |
| data_ready | output | 1 | Receive data available |
| level | output | 5 | Bytes held in the queue |
| trig_hit | output | 1 | Fill threshold reached |
| timeout_pend | output | 1 | Idle timeout pending |
| tx_flush | output | 1 | One-cycle request to empty the transmit store |
| overrun | output | 1 | One-cycle pulse for a dropped or overwritten byte |
| ctl_q | output | 8 | Retained control bits |

## Verification
The bench uses the default parameters: a depth of 16 and an idle limit of 4 ticks. With these values, a full queue is reached in 16 arrivals, and the 17th arrival shows the overrun drop. The largest threshold, 14, also fits inside the store. A timeout needs only a handful of ticks, so the directed sequence can cover the restart-by-arrival and restart-by-read cases and the priority of a read over a tick. A randomized phase then mixes arrivals, reads, ticks and occasional control writes, including mode toggles, and compares every output each cycle against a queue-based model.

// File: rtl/uart_rxq_pkg.sv
// Shared constants and helpers for the UART receive queue.
// Assumes an 8-bit control register with the threshold code in bits 7:6.
package uart_rxq_pkg;
    localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;
    localparam int         BIT_EN        = 0;
    localparam int         BIT_RX_RST    = 1;
    localparam int         BIT_TX_RST    = 2;

    // Map the two-bit threshold code to a byte count.
    function automatic int trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/uart_rxq_ctl.sv
// Control register: keeps the sticky bits and decodes one-shot reset requests.
// Assumes a write acts on the value held before it (for the enable toggle).
module uart_rxq_ctl
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q,
    output logic       rx_clr,
    output logic       tx_flush
);
    logic toggle;
    logic tx_req;

    // Decode the reset requests of this write, with an enable change forcing both.
    always_comb begin
        toggle = we && (wdata[BIT_EN] != ctl_q[BIT_EN]);
        rx_clr = (we && wdata[BIT_RX_RST]) || toggle;
        tx_req = (we && wdata[BIT_TX_RST]) || toggle;
    end

    // Hold the retained bits and register the transmit flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= tx_req;
            if (we) ctl_q <= wdata & CTL_KEEP_MASK;
        end
    end
endmodule

// File: rtl/uart_rxq_store.sv
// Circular byte store with head, tail and occupancy count.
// Assumes push is dropped when full, even if a pop happens in the same cycle.
module uart_rxq_store #(
    parameter  int DW    = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          accepted
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head, tail, head_nx, tail_nx;
    logic          take;

    // Accept and remove decisions based on the current occupancy.
    always_comb begin
        accepted = push && (count != CW'(DEPTH));
        take     = pop && (count != '0);
        dout     = (count != '0) ? mem[tail] : '0;
    end

    // Pointer wrap: natural overflow for power-of-two depths, compare otherwise.
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
        assign head_nx = head + 1'b1;
        assign tail_nx = tail + 1'b1;
    end else begin : g_cmp_wrap
        assign head_nx = (head == AW'(DEPTH - 1)) ? '0 : head + 1'b1;
        assign tail_nx = (tail == AW'(DEPTH - 1)) ? '0 : tail + 1'b1;
    end

    // Write the accepted byte into the slot at the head.
    always_ff @(posedge clk) begin
        if (accepted) mem[head] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (accepted) head <= head_nx;
            if (take)     tail <= tail_nx;
            count <= count + CW'(accepted) - CW'(take);
        end
    end
endmodule

// File: rtl/uart_rxq_idle.sv
// Idle-time detector: counts character ticks while data waits unread.
// Assumes char_tick is a single-cycle pulse; restart wins over a tick.
module uart_rxq_idle #(
    parameter  int LIMIT = 4,
    localparam int IW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic restart,
    input  logic tick,
    input  logic rd,
    output logic pend
);
    logic [IW-1:0] cnt;

    // Count ticks up to the limit and flag a timeout; a read clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (rd) pend <= 1'b0;
            if (restart || !active) begin
                cnt <= '0;
            end else if (tick && (cnt != IW'(LIMIT))) begin
                cnt <= cnt + 1'b1;
                if ((cnt == IW'(LIMIT - 1)) && !rd) pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rxq.sv
// UART receive queue top: queue or single-register mode, threshold, idle timeout.
// Assumes rx_valid, rd_strobe, ctl_we and char_tick are single-cycle strobes.
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH      = 16,
    parameter  int IDLE_TICKS = 4,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rd_strobe,
    input  logic          char_tick,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    rd_data,
    output logic          data_ready,
    output logic [CW-1:0] level,
    output logic          trig_hit,
    output logic          timeout_pend,
    output logic          tx_flush,
    output logic          overrun,
    output logic [7:0]    ctl_q
);
    logic          rx_clr, q_mode, push, pop, accepted;
    logic [7:0]    q_dout, hold_q;
    logic          hold_full;
    logic [CW-1:0] count;

    uart_rxq_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .ctl_q(ctl_q), .rx_clr(rx_clr), .tx_flush(tx_flush)
    );

    // Route strobes to the queue only in queue mode and outside a reset request.
    always_comb begin
        q_mode = ctl_q[BIT_EN];
        push   = rx_valid && q_mode && !rx_clr;
        pop    = rd_strobe && q_mode && !rx_clr;
    end

    uart_rxq_store #(.DW(8), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(push), .pop(pop),
        .din(rx_data), .dout(q_dout), .count(count), .accepted(accepted)
    );

    uart_rxq_idle #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .active(q_mode && (count != '0)),
        .restart(accepted || (pop && (count > CW'(1)))),
        .tick(char_tick), .rd(rd_strobe), .pend(timeout_pend)
    );

    // Single-register mode holding register; a new byte wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (!q_mode) begin
            if (rx_valid) begin
                hold_q    <= rx_data;
                hold_full <= 1'b1;
            end else if (rd_strobe) begin
                hold_full <= 1'b0;
            end
        end
    end

    // One-cycle overrun pulse for a dropped or overwritten byte.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= rx_valid && !rx_clr &&
                               (q_mode ? (count == CW'(DEPTH)) : hold_full);
    end

    // Output selection by mode.
    always_comb begin
        rd_data    = q_mode ? q_dout : hold_q;
        data_ready = q_mode ? (count != '0) : hold_full;
        level      = count;
        trig_hit   = q_mode ? (int'(count) >= trig_bytes(ctl_q[7:6])) : hold_full;
    end
endmodule

// File: rtl/uart_rxq_chk.sv
// Property checker for the UART receive queue, attached by bind.
// Assumes the port semantics stated in the brief.
module uart_rxq_chk
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_strobe,
    input logic          ctl_we,
    input logic [7:0]    ctl_wdata,
    input logic [7:0]    rd_data,
    input logic          data_ready,
    input logic [CW-1:0] level,
    input logic          trig_hit,
    input logic          timeout_pend,
    input logic          tx_flush,
    input logic          overrun,
    input logic [7:0]    ctl_q
);
    a_r6_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_q == ($past(ctl_wdata) & 8'hC9));

    a_r7_tx_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[2]) |=> tx_flush);

    a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[1]) |=> (level == '0) && !timeout_pend && !data_ready);

    a_r9_read_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !timeout_pend);

    a_r10_no_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |-> !timeout_pend);

    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && level == '0) |-> rd_data == 8'h00);

    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && level == CW'(DEPTH) && rx_valid && !rd_strobe && !ctl_we)
        |=> overrun && level == CW'(DEPTH));

    a_r5_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[0] |-> trig_hit == (int'(level) >= trig_bytes(ctl_q[7:6])));
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_strobe(rd_strobe),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rd_data(rd_data),
    .data_ready(data_ready), .level(level), .trig_hit(trig_hit),
    .timeout_pend(timeout_pend), .tx_flush(tx_flush), .overrun(overrun),
    .ctl_q(ctl_q)
);

// File: tb/uart_rxq_tb.sv
// Bench for uart_rxq: behavioural queue model compared on every clock.
module uart_rxq_tb;
    localparam int DEPTH = 16;
    localparam int LIMIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rd_strobe = 1'b0, char_tick = 1'b0, ctl_we = 1'b0;
    logic [7:0] rx_data = '0, ctl_wdata = '0;
    logic [7:0] rd_data, ctl_q;
    logic       data_ready, trig_hit, timeout_pend, tx_flush, overrun;
    logic [4:0] level;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rxq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_strobe(rd_strobe), .char_tick(char_tick), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .rd_data(rd_data), .data_ready(data_ready),
        .level(level), .trig_hit(trig_hit), .timeout_pend(timeout_pend),
        .tx_flush(tx_flush), .overrun(overrun), .ctl_q(ctl_q)
    );

    // Reference model state
    logic [7:0] q[$];
    logic [7:0] m_hold = '0, m_ctl = '0;
    bit         m_full = 0, m_pend = 0, m_flush = 0, m_ovr = 0;
    int         m_idle = 0;

    function automatic int thr(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Model update on each rising edge from the inputs driven half a cycle earlier.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete(); m_hold = 0; m_ctl = 0; m_full = 0; m_pend = 0;
            m_flush = 0; m_ovr = 0; m_idle = 0;
        end else begin
            bit en, tog, clr;
            int sz0;
            bit pushok, restart;
            en  = m_ctl[0];
            tog = ctl_we && (ctl_wdata[0] != m_ctl[0]);
            clr = (ctl_we && ctl_wdata[1]) || tog;
            sz0 = q.size();
            m_flush = (ctl_we && ctl_wdata[2]) || tog;
            m_ovr   = !clr && rx_valid && (en ? (sz0 == DEPTH) : m_full);
            if (clr) begin
                q.delete(); m_hold = 0; m_full = 0; m_pend = 0; m_idle = 0;
            end else if (en) begin
                pushok  = rx_valid && sz0 < DEPTH;
                restart = pushok || (rd_strobe && sz0 > 1);
                if (rd_strobe) m_pend = 0;
                if (restart || sz0 == 0) m_idle = 0;
                else if (char_tick && m_idle < LIMIT) begin
                    m_idle++;
                    if (m_idle == LIMIT && !rd_strobe) m_pend = 1;
                end
                if (rd_strobe && sz0 > 0) void'(q.pop_front());
                if (pushok) q.push_back(rx_data);
            end else begin
                if (rx_valid) begin m_hold = rx_data; m_full = 1; end
                else if (rd_strobe) m_full = 0;
            end
            if (ctl_we) m_ctl = ctl_wdata & 8'hC9;
        end
    end

    // Compare every output against the model on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit en;
            int exp_rd, exp_dr, exp_tr;
            en     = m_ctl[0];
            exp_rd = en ? ((q.size() > 0) ? int'(q[0]) : 0) : int'(m_hold);
            exp_dr = en ? int'(q.size() > 0) : int'(m_full);
            exp_tr = en ? int'(q.size() >= thr(m_ctl[7:6])) : int'(m_full);
            chk("R2", "rd_data", rd_data, exp_rd);
            chk("R2", "level", level, q.size());
            chk("R10", "data_ready", data_ready, exp_dr);
            chk("R5", "trig_hit", trig_hit, exp_tr);
            chk("R8", "timeout_pend", timeout_pend, m_pend);
            chk("R7", "tx_flush", tx_flush, m_flush);
            chk("R3", "overrun", overrun, m_ovr);
            chk("R6", "ctl_q", ctl_q, m_ctl);
        end
    end

    // Watchdog: an expired run is a failed check and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
    endtask
    task automatic pop();
        rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    endtask
    task automatic wctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
    endtask
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1; @(negedge clk); char_tick = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "level", level, 0);
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "ctl_q", ctl_q, 0);
        chk("R1", "timeout_pend", timeout_pend, 0);
        chk("R1", "tx_flush", tx_flush, 0);
        chk("R1", "rd_data", rd_data, 0);

        wctl(8'h01);
        chk("R7", "tx_flush on enable toggle", tx_flush, 1);
        chk("R6", "ctl_q", ctl_q, 8'h01);
        push(8'hA1); push(8'hB2); push(8'hC3);
        chk("R2", "level", level, 3);
        chk("R2", "oldest", rd_data, 8'hA1);
        pop();
        chk("R2", "next", rd_data, 8'hB2);
        pop(); pop();
        chk("R4", "empty rd_data", rd_data, 0);
        pop();
        chk("R4", "level after empty read", level, 0);

        wctl(8'h41);
        push(8'h01); push(8'h02); push(8'h03);
        chk("R5", "below 4", trig_hit, 0);
        push(8'h04);
        chk("R5", "at 4", trig_hit, 1);
        for (int i = 0; i < 12; i++) push(8'h10 + 8'(i));
        chk("R3", "full level", level, 16);
        push(8'hEE);
        chk("R3", "overrun pulse", overrun, 1);
        chk("R3", "level unchanged", level, 16);
        chk("R3", "head unchanged", rd_data, 8'h01);

        wctl(8'h43);
        chk("R7", "rx reset empties", level, 0);
        chk("R6", "reset bit not kept", ctl_q, 8'h41);
        wctl(8'h45);
        chk("R7", "tx flush pulse", tx_flush, 1);

        push(8'h55); push(8'h66);
        tick(3);
        chk("R8", "three ticks", timeout_pend, 0);
        tick(1);
        chk("R8", "fourth tick", timeout_pend, 1);
        pop();
        chk("R9", "read clears", timeout_pend, 0);
        tick(3);
        chk("R9", "restarted count", timeout_pend, 0);
        tick(1);
        chk("R9", "pending again", timeout_pend, 1);
        pop();
        push(8'h77); tick(2); push(8'h78); tick(3);
        chk("R8", "restart by arrival", timeout_pend, 0);
        tick(1);
        chk("R8", "after restart", timeout_pend, 1);
        wctl(8'h43);
        chk("R7", "clear cancels timeout", timeout_pend, 0);

        // R11: arrival during reset request is discarded
        rx_valid = 1; rx_data = 8'h99; ctl_we = 1; ctl_wdata = 8'h43;
        @(negedge clk); rx_valid = 0; ctl_we = 0;
        chk("R11", "arrival ignored", level, 0);

        wctl(8'h00);
        chk("R7", "disable flushes tx", tx_flush, 1);
        push(8'h5A);
        chk("R10", "data_ready", data_ready, 1);
        chk("R10", "rd_data", rd_data, 8'h5A);
        push(8'h6B);
        chk("R10", "overwrite overrun", overrun, 1);
        chk("R10", "overwritten", rd_data, 8'h6B);
        tick(6);
        chk("R10", "no timeout", timeout_pend, 0);
        pop();
        chk("R10", "read clears ready", data_ready, 0);

        wctl(8'hFF);
        chk("R6", "mask C9", ctl_q, 8'hC9);
        for (int i = 0; i < 13; i++) push(8'(i));
        chk("R5", "13 below 14", trig_hit, 0);
        push(8'h20);
        chk("R5", "at 14", trig_hit, 1);
        wctl(8'h89);
        chk("R5", "level kept, code 10", level, 14);

        // Randomized mix
        for (int i = 0; i < 6000; i++) begin
            rx_valid  = ($urandom % 3) == 0;
            rx_data   = 8'($urandom);
            rd_strobe = ($urandom % 4) == 0;
            char_tick = ($urandom % 2) == 0;
            ctl_we    = ($urandom % 120) == 0;
            ctl_wdata = 8'($urandom) | ((($urandom % 5) != 0) ? 8'h01 : 8'h00);
            if (ctl_we && ($urandom % 2) == 0) ctl_wdata[1] = 1'b0;
            @(negedge clk);
        end
        rx_valid = 0; rd_strobe = 0; char_tick = 0; ctl_we = 0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule